// File: doc/BRIEF.md
# Asynchronous Transmit Quadlet Queue

This block buffers outgoing asynchronous packets one quadlet (32 bits) at a time between a host and a packet transmitter. The host loads a packet through two write-only transfer ports. A write on the interior port stores a quadlet that is not the end of a packet. A write on the final port stores the quadlet that closes the packet. Every stored entry carries an end-of-packet tag.

Each host write first lands in a one-entry transfer register. One clock later it moves into the queue. While a quadlet is waiting in the transfer register, a written flag stays low. When the quadlet reaches the queue, the flag rises and a written interrupt becomes pending. If the queue is full when the quadlet tries to enter, the quadlet is lost and a write-error interrupt becomes pending instead. Four occupancy flags let the host pace its writes.

On the read side, the transmitter sees a packet as available only once a complete packet is held in the queue. It pops quadlets in order. Popping the final quadlet of a packet produces exactly one confirmation pulse.

Top module: `atxq_top`

## Requirements
- R1: After a synchronous reset the block shows: empty=1, full=0, almost-full=0, five-free=1, written=1, both pending bits 0, interrupt 0, packet-available 0, confirmation 0.
- R2: A write on `wr_next` stores `wr_data` with end tag 0. A write on `wr_last` stores it with end tag 1. If both strobes are high in the same cycle, the write counts as a single final-port write. Entries leave in write order, and the head entry is shown on `rd_data`/`rd_eop`.
- R3: The written flag goes low after the edge that samples a write. It returns high after the next edge, provided the quadlet entered the queue and no new write arrived. Pending bit 0 (written) sets on that same edge.
- R4: With N entries held out of DEPTH, the flags mean the following: full when N equals DEPTH; almost-full exactly when N equals DEPTH-1; five-free when DEPTH-N is at least 5; empty when N equals 0. A quadlet counts once it has left the transfer register.
- R5: A quadlet that reaches the queue while it holds DEPTH entries is discarded. The held contents stay unchanged, pending bit 1 (write error) sets, and the written flag stays low.
- R6: Setting bit i of `irq_clr` clears pending bit i on the next edge. If a new event for bit i happens in the same cycle, the set wins.
- R7: `irq_out` is high exactly when some pending bit has its matching `irq_en` bit set.
- R8: `rd_pkt_avail` is high only while at least one entry with end tag 1 is held. A `rd_pop` while it is low is ignored and leaves the contents unchanged.
- R9: `conf_valid` pulses high for one cycle after the edge that pops an entry with end tag 1, and never at any other time. This gives one pulse per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_next | input | 1 | Write strobe, interior-quadlet port |
| wr_last | input | 1 | Write strobe, final-quadlet port |
| wr_data | input | 32 | Quadlet being written |
| irq_clr | input | 2 | Write-1-to-clear for pending bits (0 written, 1 error) |
| irq_en | input | 2 | Interrupt enables, one per pending bit |
| q_full | output | 1 | No space left |
| q_afull | output | 1 | Exactly one entry free |
| q_five_free | output | 1 | At least five entries free |
| q_empty | output | 1 | Nothing held |
| xfer_written | output | 1 | Transfer register has been emptied into the queue |
| irq_pend | output | 2 | Pending interrupt bits |
| irq_out | output | 1 | OR of the enabled pending bits |
| rd_pop | input | 1 | Transmitter removes the head entry |
| rd_pkt_avail | output | 1 | A complete packet is held |
| rd_data | output | 32 | Head entry data |
| rd_eop | output | 1 | Head entry end tag |
| conf_valid | output | 1 | One-cycle confirmation per popped packet |

## Verification
The bench drives the queue until it is full and then writes again. A design that kept the extra quadlet, failed to flag the error, or raised the written flag would be caught. It also walks the count through DEPTH-1 and DEPTH-5, where an off-by-one error in the almost-full or five-free compare shows up. It pops while only a partial packet is held; a design that started a partial packet would lose data or pulse a confirmation. It also aims both strobes at the same cycle and makes a clear collide with a new event, which exposes a wrong end tag or a clear that beats the set.

// File: rtl/atxq_pkg.sv
package atxq_pkg;

    localparam int QW    = 32;
    localparam int IRQ_W = 2;
    localparam int IRQ_WRITTEN = 0;
    localparam int IRQ_WERR    = 1;

    typedef logic [QW-1:0] quadlet_t;

    typedef struct packed {
        logic     eop;
        quadlet_t data;
    } qentry_t;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_NEXT = 2'd1,
        WK_LAST = 2'd2
    } wkind_t;

    // Final port wins when both strobes are present.
    function automatic wkind_t decode_write(input logic nxt, input logic lst);
        if (lst)      return WK_LAST;
        else if (nxt) return WK_NEXT;
        else          return WK_NONE;
    endfunction

    function automatic qentry_t make_entry(input wkind_t k, input quadlet_t d);
        qentry_t e;
        e.eop  = (k == WK_LAST);
        e.data = d;
        return e;
    endfunction

endpackage

// File: rtl/atxq_xfer.sv
module atxq_xfer
    import atxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_next,
    input  logic     wr_last,
    input  quadlet_t wr_data,
    input  logic     store_full,
    output logic     push_v,
    output qentry_t  push_entry,
    output logic     drop,
    output logic     written
);

    wkind_t  kind;
    logic    hold_v;
    qentry_t hold_q;

    assign kind = decode_write(wr_next, wr_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v  <= 1'b0;
            hold_q  <= '0;
            written <= 1'b1;
        end else begin
            hold_v <= (kind != WK_NONE);
            if (kind != WK_NONE) begin
                hold_q <= make_entry(kind, wr_data);
            end
            if (kind != WK_NONE) begin
                written <= 1'b0;
            end else if (push_v) begin
                written <= 1'b1;
            end
        end
    end

    assign push_v     = hold_v && !store_full;
    assign drop       = hold_v && store_full;
    assign push_entry = hold_q;

    AST_WRITTEN_LOW_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        hold_v |-> !written); // R3
    AST_WRITTEN_SETS_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
        (push_v && !wr_next && !wr_last) |=> written); // R3
    AST_DROP_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (drop && !wr_next && !wr_last) |=> !written); // R5

endmodule

// File: rtl/atxq_store.sv
module atxq_store
    import atxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push_v,
    input  qentry_t push_entry,
    input  logic    pop_req,
    output qentry_t head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic    pkt_avail,
    output logic    conf
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    qentry_t            mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [CNT_W-1:0]   pkts;
    logic               pop_ok;
    logic               inc_pkt, dec_pkt;

    assign head      = mem[rptr];
    assign pkt_avail = (pkts != '0);
    assign pop_ok    = pop_req && pkt_avail;
    assign inc_pkt   = push_v && push_entry.eop;
    assign dec_pkt   = pop_ok && head.eop;

    always_ff @(posedge clk) begin
        if (push_v) begin
            mem[wptr] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            pkts  <= '0;
            conf  <= 1'b0;
        end else begin
            if (push_v) begin
                wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            end
            case ({push_v, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            case ({inc_pkt, dec_pkt})
                2'b10:   pkts <= pkts + 1'b1;
                2'b01:   pkts <= pkts - 1'b1;
                default: pkts <= pkts;
            endcase
            conf <= dec_pkt;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !push_v); // R5
    AST_PKTS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        pkts <= count); // R8
    AST_IDLE_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !pkt_avail && !push_v) |=> $stable(count)); // R8
    AST_CONF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (conf && !dec_pkt) |=> !conf); // R9

endmodule

// File: rtl/atxq_flags.sv
module atxq_flags #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       afull,
    output logic                       five_free,
    output logic                       empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    logic [CNT_W-1:0] free_n;

    assign free_n = CNT_W'(DEPTH) - count;
    assign full   = (count == CNT_W'(DEPTH));
    assign afull  = (free_n == CNT_W'(1));
    assign empty  = (count == '0);

    generate
        if (DEPTH >= 5) begin : g_five
            assign five_free = (free_n >= CNT_W'(5));
        end else begin : g_nofive
            assign five_free = 1'b0;
        end
    endgenerate

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({full, afull, empty})); // R4
    AST_FULL_NOT_FIVE: assert property (@(posedge clk) disable iff (rst)
        full |-> !five_free); // R4

endmodule

// File: rtl/atxq_irq.sv
module atxq_irq
    import atxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] set_ev,
    input  logic [IRQ_W-1:0] clr,
    input  logic [IRQ_W-1:0] en,
    output logic [IRQ_W-1:0] pend,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr) | set_ev;
        end
    end

    assign irq = |(pend & en);

    AST_SET_WINS_W: assert property (@(posedge clk) disable iff (rst)
        set_ev[IRQ_WRITTEN] |=> pend[IRQ_WRITTEN]); // R6
    AST_SET_WINS_E: assert property (@(posedge clk) disable iff (rst)
        set_ev[IRQ_WERR] |=> pend[IRQ_WERR]); // R6
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr[IRQ_WERR] && !set_ev[IRQ_WERR]) |=> !pend[IRQ_WERR]); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((pend & en) == '0) |-> !irq); // R7

endmodule

// File: rtl/atxq_top.sv
module atxq_top
    import atxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_next,
    input  logic        wr_last,
    input  logic [31:0] wr_data,
    input  logic [1:0]  irq_clr,
    input  logic [1:0]  irq_en,
    output logic        q_full,
    output logic        q_afull,
    output logic        q_five_free,
    output logic        q_empty,
    output logic        xfer_written,
    output logic [1:0]  irq_pend,
    output logic        irq_out,
    input  logic        rd_pop,
    output logic        rd_pkt_avail,
    output logic [31:0] rd_data,
    output logic        rd_eop,
    output logic        conf_valid
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_v, drop;
    qentry_t          push_entry, head;
    logic [CNT_W-1:0] count;
    logic [IRQ_W-1:0] set_ev;

    atxq_xfer u_xfer (
        .clk        (clk),
        .rst        (rst),
        .wr_next    (wr_next),
        .wr_last    (wr_last),
        .wr_data    (wr_data),
        .store_full (q_full),
        .push_v     (push_v),
        .push_entry (push_entry),
        .drop       (drop),
        .written    (xfer_written)
    );

    atxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_v     (push_v),
        .push_entry (push_entry),
        .pop_req    (rd_pop),
        .head       (head),
        .count      (count),
        .pkt_avail  (rd_pkt_avail),
        .conf       (conf_valid)
    );

    atxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .count     (count),
        .full      (q_full),
        .afull     (q_afull),
        .five_free (q_five_free),
        .empty     (q_empty)
    );

    always_comb begin
        set_ev              = '0;
        set_ev[IRQ_WRITTEN] = push_v;
        set_ev[IRQ_WERR]    = drop;
    end

    atxq_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_ev (set_ev),
        .clr    (irq_clr),
        .en     (irq_en),
        .pend   (irq_pend),
        .irq    (irq_out)
    );

    assign rd_data = head.data;
    assign rd_eop  = head.eop;

    AST_EMPTY_NO_PKT: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> !rd_pkt_avail); // R8
    AST_CONF_AFTER_EOP_POP: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && rd_pkt_avail && rd_eop) |=> conf_valid); // R9

endmodule

// File: tb/atxq_top_bench.sv
module atxq_top_bench;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_next, wr_last, rd_pop;
    logic [31:0] wr_data;
    logic [1:0]  irq_clr, irq_en;
    logic        q_full, q_afull, q_five_free, q_empty, xfer_written;
    logic [1:0]  irq_pend;
    logic        irq_out, rd_pkt_avail, rd_eop, conf_valid;
    logic [31:0] rd_data;

    always #2.5 clk = ~clk;

    atxq_top #(.DEPTH(DEPTH)) u_atxq_top (
        .clk(clk), .rst(rst), .wr_next(wr_next), .wr_last(wr_last),
        .wr_data(wr_data), .irq_clr(irq_clr), .irq_en(irq_en),
        .q_full(q_full), .q_afull(q_afull), .q_five_free(q_five_free),
        .q_empty(q_empty), .xfer_written(xfer_written), .irq_pend(irq_pend),
        .irq_out(irq_out), .rd_pop(rd_pop), .rd_pkt_avail(rd_pkt_avail),
        .rd_data(rd_data), .rd_eop(rd_eop), .conf_valid(conf_valid)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state (values after the most recent edge).
    logic [31:0] m_data [DEPTH];
    logic        m_eop  [DEPTH];
    int          m_head, m_cnt, m_pkts;
    logic        m_hold_v, m_hold_e, m_written, m_conf;
    logic [31:0] m_hold_d;
    logic [1:0]  m_pend;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_head = 0; m_cnt = 0; m_pkts = 0;
        m_hold_v = 0; m_hold_e = 0; m_hold_d = '0;
        m_written = 1; m_conf = 0; m_pend = '0;
    endtask

    // Advance the model over one edge with the inputs currently driven.
    task automatic model_step();
        logic pop_ok, push, dropq, pop_eop;
        logic [1:0] setv;
        pop_ok  = rd_pop && (m_pkts > 0);
        pop_eop = pop_ok && m_eop[m_head];
        push    = m_hold_v && (m_cnt < DEPTH);
        dropq   = m_hold_v && (m_cnt == DEPTH);
        if (push) begin
            m_data[(m_head + m_cnt) % DEPTH] = m_hold_d;
            m_eop[(m_head + m_cnt) % DEPTH]  = m_hold_e;
            m_cnt++;
            if (m_hold_e) m_pkts++;
        end
        if (pop_ok) begin
            m_head = (m_head + 1) % DEPTH;
            m_cnt--;
            if (pop_eop) m_pkts--;
        end
        setv = {dropq, push};
        m_pend = (m_pend & ~irq_clr) | setv;
        m_conf = pop_eop;
        if (wr_next || wr_last) m_written = 0;
        else if (push)          m_written = 1;
        m_hold_v = wr_next || wr_last;
        if (m_hold_v) begin
            m_hold_d = wr_data;
            m_hold_e = wr_last;
        end
    endtask

    task automatic check_all();
        chk("R4", "full",  {31'd0, q_full},      {31'd0, m_cnt == DEPTH});
        chk("R4", "afull", {31'd0, q_afull},     {31'd0, m_cnt == DEPTH - 1});
        chk("R4", "five",  {31'd0, q_five_free}, {31'd0, (DEPTH - m_cnt) >= 5});
        chk("R4", "empty", {31'd0, q_empty},     {31'd0, m_cnt == 0});
        chk("R3", "written", {31'd0, xfer_written}, {31'd0, m_written});
        chk("R6", "pend",  {30'd0, irq_pend}, {30'd0, m_pend});
        chk("R7", "irq",   {31'd0, irq_out},  {31'd0, |(m_pend & irq_en)});
        chk("R8", "avail", {31'd0, rd_pkt_avail}, {31'd0, m_pkts > 0});
        chk("R9", "conf",  {31'd0, conf_valid},   {31'd0, m_conf});
        if (m_cnt > 0) begin
            chk("R2", "data", rd_data, m_data[m_head]);
            chk("R2", "eop",  {31'd0, rd_eop}, {31'd0, m_eop[m_head]});
        end
    endtask

    // Drive one cycle: inputs set at negedge, model advanced, then compared.
    task automatic cyc(input logic n, input logic l, input logic [31:0] d,
                       input logic p, input logic [1:0] c, input logic [1:0] e);
        wr_next = n; wr_last = l; wr_data = d; rd_pop = p; irq_clr = c; irq_en = e;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        rst = 1; wr_next = 0; wr_last = 0; wr_data = '0; rd_pop = 0; irq_clr = '0; irq_en = '0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        model_reset();
        // R1: reset state
        chk("R1", "empty", {31'd0, q_empty}, 32'd1);
        chk("R1", "full",  {31'd0, q_full},  32'd0);
        chk("R1", "five",  {31'd0, q_five_free}, 32'd1);
        chk("R1", "written", {31'd0, xfer_written}, 32'd1);
        chk("R1", "pend",  {30'd0, irq_pend}, 32'd0);
        chk("R1", "avail", {31'd0, rd_pkt_avail}, 32'd0);
        chk("R1", "conf",  {31'd0, conf_valid}, 32'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1394));
        do_reset();

        // R2: both strobes together act as a final-port write.
        cyc(1, 1, 32'hA5A5_0001, 0, 2'b00, 2'b11);
        cyc(0, 0, 32'h0, 0, 2'b00, 2'b11);
        chk("R2", "dual strobe eop", {31'd0, rd_eop}, 32'd1);
        // R9: pop it, one confirmation
        cyc(0, 0, 32'h0, 1, 2'b01, 2'b11);
        chk("R9", "conf pulse", {31'd0, conf_valid}, 32'd1);
        cyc(0, 0, 32'h0, 0, 2'b00, 2'b11);
        chk("R9", "conf single", {31'd0, conf_valid}, 32'd0);

        // R8: partial packet is not started; pop ignored.
        cyc(1, 0, 32'h1111_0000, 0, 2'b00, 2'b00);
        cyc(0, 0, 32'h0, 1, 2'b00, 2'b00);
        cyc(0, 0, 32'h0, 1, 2'b00, 2'b00);
        chk("R8", "partial kept", {31'd0, q_empty}, 32'd0);

        // R4/R5: fill to full, walking through five-free and almost-full.
        for (int i = 0; i < DEPTH - 1; i++) begin
            cyc(1, 0, 32'h2000_0000 + i, 0, 2'b00, 2'b10);
        end
        cyc(0, 0, 32'h0, 0, 2'b00, 2'b10);
        chk("R4", "full reached", {31'd0, q_full}, 32'd1);
        cyc(0, 1, 32'hDEAD_BEEF, 0, 2'b00, 2'b10);
        cyc(0, 0, 32'h0, 0, 2'b00, 2'b10);
        chk("R5", "drop err", {31'd0, irq_pend[1]}, 32'd1);
        chk("R5", "written low", {31'd0, xfer_written}, 32'd0);
        chk("R7", "err irq", {31'd0, irq_out}, 32'd1);
        // R6: clear colliding with a new drop, set wins
        cyc(0, 1, 32'hDEAD_0002, 0, 2'b00, 2'b10);
        cyc(0, 0, 32'h0, 0, 2'b10, 2'b10);
        chk("R6", "set wins", {31'd0, irq_pend[1]}, 32'd1);
        cyc(0, 0, 32'h0, 0, 2'b10, 2'b10);
        chk("R6", "cleared", {31'd0, irq_pend[1]}, 32'd0);

        // Random phase with periodic resets.
        do_reset();
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 30, (r >= 30 && r < 42) || r == 99, $urandom(),
                $urandom_range(0, 99) < 45,
                2'($urandom_range(0, 3) & {1'b1, ($urandom_range(0, 3) == 0)}),
                2'($urandom_range(0, 3)));
            if (k % 2000 == 1999) do_reset();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule